// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of one conversion of a 9-bit fully differential successive-approximation converter. Eight input channels share the converter through an analog multiplexer. A single start strobe launches a conversion. The block then drives the capacitor-array phase controls in a fixed order. Each conversion first resets the array (discharge), then lets the comparator store its output offset, then tracks the selected input (sample). After that it resolves the code one bit per clock, from the most significant bit down, using a single comparator decision for each bit.

The comparator input `cmp_i` is high when the held input is at or above the DAC code currently driven on `dac_code_o`. The finished code is offset binary. Midscale `0x100` stands for zero differential input, so bit 8 of the result is the sign. Bit 8 is 1 when the differential input is zero or positive. Software sets the length of the discharge, offset and sample phases in clocks. With the default lengths a full conversion needs far fewer clocks than the per-conversion budget of about 6.25 µs, which is what eight channels at 20 kS/s each require.

The state machine has six states: `ST_IDLE`, `ST_DISCHARGE`, `ST_OFFSET`, `ST_SAMPLE`, `ST_TRIAL` and `ST_DONE`. Its transitions are:
- start: `ST_IDLE` to `ST_DISCHARGE`, on `start_i`.
- discharge expiry: `ST_DISCHARGE` to `ST_OFFSET`.
- offset expiry: `ST_OFFSET` to `ST_SAMPLE`.
- sample expiry: `ST_SAMPLE` to `ST_TRIAL`.
- last trial: `ST_TRIAL` to `ST_DONE`, after the bit-0 decision.
- retire: `ST_DONE` to `ST_IDLE`, unconditionally.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `discharge_o`, `offset_o`, `sample_o`, `done_o` and `busy_o` are 0 and `result_o` is 0.
- R2: A `start_i` seen in `ST_IDLE` at a clock edge raises `discharge_o` and `busy_o` in the following cycle. `discharge_o` stays high for `dis_len_i` clocks.
- R3: When discharge ends, `offset_o` is high in the next cycle and stays high for `oos_len_i` clocks. No other phase output is high during this time.
- R4: When offset storage ends, `sample_o` is high in the next cycle and stays high for `smp_len_i` clocks.
- R5: After sampling come exactly 9 trial clocks. In the first trial clock `dac_code_o` is `0x100`. In each trial clock `dac_code_o` is the code decided so far with the trial bit set. At the end of that clock the bit is kept if `cmp_i` is 1 and cleared if `cmp_i` is 0.
- R6: In the cycle right after the ninth trial clock, `done_o` is high for exactly one clock. In that cycle `result_o` holds the resolved code, which for an ideal comparator equals the held input in offset binary.
- R7: `result_o` changes only in a cycle where `done_o` is high. It holds its value through the idle time and through the whole of the next conversion.
- R8: `result_o[8]` is the sign bit. It is 1 for a differential input at or above zero (code `0x100` and higher) and 0 for a negative input.
- R9: A `start_i` that arrives while `busy_o` is high is ignored. This includes the `ST_DONE` cycle: the conversion in flight is not disturbed, and no discharge follows it.
- R10: A phase length of 0 is treated as 1 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion start strobe |
| dis_len_i | input | 8 | Discharge phase length in clocks (0 acts as 1) |
| oos_len_i | input | 8 | Offset-storage phase length in clocks (0 acts as 1) |
| smp_len_i | input | 8 | Sample phase length in clocks (0 acts as 1) |
| cmp_i | input | 1 | Comparator decision: 1 when the held input is at or above `dac_code_o` |
| discharge_o | output | 1 | Capacitor array discharge phase |
| offset_o | output | 1 | Comparator output-offset storage phase |
| sample_o | output | 1 | Track/sample phase; the input is held when it falls |
| dac_code_o | output | 9 | DAC switch code for the current trial |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-clock pulse when a result is ready |
| result_o | output | 9 | Last resolved code, offset binary, bit 8 = sign |

## Verification
A start strobe can coincide with a running conversion. The most delicate case is the `ST_DONE` cycle, where the retire transition and an apparent new start meet in the same clock. The bench drives `start_i` during a middle trial clock and, separately, during the done cycle. It judges the outcome in two ways: the trial count must still be exactly nine, and `discharge_o` and `busy_o` must both be low in the cycle after `done_o`. Random signed inputs with random phase lengths, including zero, are mixed with full-scale, zero and minus-one inputs. Each resolved code and its sign bit is checked against the value the bench held.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DISCHARGE,
        ST_OFFSET,
        ST_SAMPLE,
        ST_TRIAL,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/sar_phase_timer.sv
// Loadable down-counter that times one analog phase; a zero length acts as one clock.
module sar_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (len_i == '0) ? '0 : (len_i - ONE);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expire_o = (cnt_q == '0);

endmodule

// File: rtl/sar_approx_reg.sv
// Trial/decision register: walks a one-hot trial mask from MSB to LSB.
module sar_approx_reg #(
    parameter int RES_BITS = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic                init_i,
    input  logic                step_i,
    input  logic                cmp_i,
    output logic [RES_BITS-1:0] code_o,
    output logic [RES_BITS-1:0] resolved_o,
    output logic                last_o
);
    localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [RES_BITS-1:0] code_q;
    logic [RES_BITS-1:0] mask_q;
    logic [RES_BITS-1:0] code_d;

    // Per bit: drop the trial bit on a low decision, then raise the next trial bit.
    for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
        logic kept;
        assign kept = cmp_i ? code_q[i] : (code_q[i] & ~mask_q[i]);
        if (i == RES_BITS - 1) begin : g_top
            assign code_d[i] = kept;
        end else begin : g_low
            assign code_d[i] = kept | mask_q[i+1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (clear_i) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (init_i) begin
            code_q <= MSB_ONE;
            mask_q <= MSB_ONE;
        end else if (step_i) begin
            code_q <= code_d;
            mask_q <= mask_q >> 1;
        end
    end

    assign code_o     = code_q;
    assign resolved_o = code_d;
    assign last_o     = mask_q[0];

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int RES_BITS = 9,
    parameter int CNT_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CNT_W-1:0]    dis_len_i,
    input  logic [CNT_W-1:0]    oos_len_i,
    input  logic [CNT_W-1:0]    smp_len_i,
    input  logic                cmp_i,
    output logic                discharge_o,
    output logic                offset_o,
    output logic                sample_o,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [RES_BITS-1:0] result_o
);
    localparam logic [RES_BITS-1:0] MID_CODE = {1'b1, {(RES_BITS-1){1'b0}}};

    seq_state_t state_q, state_d;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_expire;
    logic             sar_clear, sar_init, sar_step, sar_last;
    logic [RES_BITS-1:0] sar_code, sar_resolved;
    logic [RES_BITS-1:0] result_q;

    sar_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (tmr_load),
        .len_i    (tmr_len),
        .expire_o (tmr_expire)
    );

    sar_approx_reg #(.RES_BITS(RES_BITS)) u_approx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (sar_clear),
        .init_i     (sar_init),
        .step_i     (sar_step),
        .cmp_i      (cmp_i),
        .code_o     (sar_code),
        .resolved_o (sar_resolved),
        .last_o     (sar_last)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i)    state_d = ST_DISCHARGE;
            ST_DISCHARGE: if (tmr_expire) state_d = ST_OFFSET;
            ST_OFFSET:    if (tmr_expire) state_d = ST_SAMPLE;
            ST_SAMPLE:    if (tmr_expire) state_d = ST_TRIAL;
            ST_TRIAL:     if (sar_last)   state_d = ST_DONE;
            ST_DONE:                      state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath controls
    always_comb begin
        discharge_o = 1'b0;
        offset_o    = 1'b0;
        sample_o    = 1'b0;
        done_o      = 1'b0;
        tmr_load    = 1'b0;
        tmr_len     = dis_len_i;
        sar_clear   = 1'b0;
        sar_init    = 1'b0;
        sar_step    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tmr_load  = start_i;
                sar_clear = start_i;
            end
            ST_DISCHARGE: begin
                discharge_o = 1'b1;
                tmr_load    = tmr_expire;
                tmr_len     = oos_len_i;
            end
            ST_OFFSET: begin
                offset_o = 1'b1;
                tmr_load = tmr_expire;
                tmr_len  = smp_len_i;
            end
            ST_SAMPLE: begin
                sample_o = 1'b1;
                sar_init = tmr_expire;
            end
            ST_TRIAL: begin
                sar_step = 1'b1;
            end
            ST_DONE: begin
                done_o = 1'b1;
            end
            default: ;
        endcase
    end

    // Result register: loaded with the final decision on the last trial
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              result_q <= '0;
        else if (state_q == ST_TRIAL && sar_last) result_q <= sar_resolved;
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign dac_code_o = sar_code;
    assign result_o   = result_q;

    // R3: offset storage only ever opens straight out of discharge
    a_r3_offset_after_discharge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(offset_o) |-> $past(discharge_o));

    // R4: sampling only ever opens straight out of offset storage
    a_r4_sample_after_offset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_o) |-> $past(offset_o));

    // R5: the first trial presents the midscale code
    a_r5_first_trial_mid: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_o) |-> (dac_code_o == MID_CODE));

    // R6: done is a single-clock pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: the result moves only together with done
    a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R9: once past discharge, no new discharge inside the same busy span
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !discharge_o) |=> !discharge_o);

endmodule

// File: tb/test_sar_seq_ctrl.sv
module test_sar_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int RES_BITS   = 9;
    localparam int CNT_W      = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CNT_W-1:0] dis_len = 8'd1, oos_len = 8'd1, smp_len = 8'd1;
    logic cmp;
    logic discharge, offset, sample, busy, done;
    logic [RES_BITS-1:0] dac_code, result;
    logic [RES_BITS-1:0] vin_code = '0;
    logic [RES_BITS-1:0] held = '0;

    int n_chk = 0;
    int n_fail = 0;

    sar_seq_ctrl #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) i_sar_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .dis_len_i(dis_len), .oos_len_i(oos_len), .smp_len_i(smp_len),
        .cmp_i(cmp), .discharge_o(discharge), .offset_o(offset),
        .sample_o(sample), .dac_code_o(dac_code), .busy_o(busy),
        .done_o(done), .result_o(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Ideal sample-and-hold plus comparator
    always @(posedge clk) if (sample) held <= vin_code;
    assign cmp = (held >= dac_code);

    function automatic int exp_len(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit phase_sig(input int sel);
        case (sel)
            0:       return discharge;
            1:       return offset;
            default: return sample;
        endcase
    endfunction

    task automatic count_high(input int sel, output int n);
        n = 0;
        while (phase_sig(sel) && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic run_conv(input int vin, input int d, input int o, input int s,
                            input bit poke_busy, input bit poke_done);
        int n;
        logic [RES_BITS-1:0] prev, exp_code;
        exp_code = RES_BITS'(vin + 256);
        prev     = result;
        vin_code = exp_code;
        dis_len = CNT_W'(d); oos_len = CNT_W'(o); smp_len = CNT_W'(s);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        check(discharge && busy, "R2 discharge after start", int'(discharge), 1);
        count_high(0, n);
        check(n == exp_len(d), "R2 R10 discharge length", n, exp_len(d));
        check(offset && !discharge && !sample, "R3 offset follows discharge", int'(offset), 1);
        count_high(1, n);
        check(n == exp_len(o), "R3 R10 offset length", n, exp_len(o));
        count_high(2, n);
        check(n == exp_len(s), "R4 R10 sample length", n, exp_len(s));
        check(dac_code == 9'h100, "R5 first trial code", int'(dac_code), 256);
        check(result == prev, "R7 result held during conversion", int'(result), int'(prev));
        vin_code = RES_BITS'($urandom);
        n = 0;
        while (busy && !done && n < 100) begin
            start = (poke_busy && n == 3);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        check(n == 9, "R5 R9 trial clocks", n, 9);
        check(done == 1'b1, "R6 done after last trial", int'(done), 1);
        check(result == exp_code, "R6 resolved code", int'(result), int'(exp_code));
        check(result[8] == (vin >= 0), "R8 sign bit", int'(result[8]), int'(vin >= 0));
        if (poke_done) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done, "R6 done one clock", int'(done), 0);
        check(!busy && !discharge, "R9 start during busy ignored", int'(busy | discharge), 0);
        check(result == exp_code, "R7 result kept after done", int'(result), int'(exp_code));
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        logic [RES_BITS-1:0] keep;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        check(!discharge && !offset && !sample && !done && !busy && result == '0,
              "R1 reset state", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && result == '0, "R1 after reset", int'(busy), 0);

        // Directed corners
        run_conv(255, 1, 1, 1, 1'b0, 1'b0);
        run_conv(-256, 0, 0, 0, 1'b1, 1'b1);
        run_conv(0, 3, 2, 4, 1'b0, 1'b1);
        run_conv(-1, 7, 0, 2, 1'b1, 1'b0);
        run_conv(1, 2, 5, 0, 1'b0, 1'b0);

        // Constrained random
        for (int k = 0; k < 40; k++) begin
            run_conv(int'($urandom_range(511)) - 256,
                     int'($urandom_range(5)), int'($urandom_range(5)),
                     int'($urandom_range(5)),
                     1'($urandom_range(1)), 1'($urandom_range(1)));
        end

        // Idle hold of the result
        keep = result;
        vin_code = ~vin_code;
        repeat (6) @(negedge clk);
        check(result == keep && !busy, "R7 result held while idle", int'(result), int'(keep));
        finish_run();
    end

endmodule